// File: doc/BRIEF.md
# Interpolating Quadrature Direct Digital Synthesizer

This block generates a pair of signed sample streams, one following sine and one following cosine, at a frequency set by a tuning word. A wide phase register advances by the tuning word on every enabled clock. A short slice from its top forms the working phase. Its three highest bits pick one of eight octants of the circle. The remaining bits are mapped into the first octant, where a 16-point table supplies a starting sample and a small slope. The offset inside each table interval is multiplied by that slope and added to the sample, so the waveform is filled in by linear interpolation rather than by a large table.

Both outputs share the octant logic and the table. The table provides a sine-of-angle lane and a cosine-of-angle lane. A swap control decides which lane drives which output, and the top phase bits set the signs. The datapath is registered in three stages after the phase register, so each output word follows the phase register by a fixed three clocks. An analog converter, if one is used, sits outside the block.

Top module: `quad_interp_dds`

## Requirements
- R1: The 24-bit phase register adds `freq_word` on every clock edge where `run_en` is high and wraps modulo 2^24. The working phase is its top 13 bits, acc[23:11].
- R2: While `run_en` is low, the phase register keeps its value. From the third clock edge after the first edge that sampled `run_en` low, both outputs stay constant.
- R3: The phase register value present after clock edge k appears on `sin_out` and `cos_out` after clock edge k+3.
- R4: Reset is synchronous and active-low. While it is held, the phase register and both outputs are 0. After release, the phase register starts from 0.
- R5: When phase bit 10 is 1, the ten phase bits [9:0] are inverted before the table lookup. This mirrors odd octants, so phase 1024 (acc = 2^21) gives sin 180 and cos 180.
- R6: When phase bit 11 XOR phase bit 10 is 1, the sine output takes the table's cosine lane and the cosine output takes its sine lane. Phase 2592 gives sin 234 and cos -104.
- R7: Phase bit 12 negates the sine output. Phase bit 12 XOR phase bit 11 negates the cosine output. Adding 4096 to the phase exactly negates both outputs (phase 544 gives 104/234; phase 4640 gives -104/-234).
- R8: The table index is folded bits [9:6] and the interval offset is folded bits [5:0]. Each of the 16 points k is spaced pi/64 apart and stores round(255*sin) and round(255*cos) of its angle. It also stores a 4-bit slope equal to the difference to the next point. A lane's value is sample + floor((offset*slope + 32)/64), with a negative slope on the cosine lane. Phase 512 gives 98/236.
- R9: Both outputs stay within 3 LSB of 255*sin(2*pi*acc/2^24) and 255*cos(2*pi*acc/2^24) of the phase register value they represent.
- R10: The four cardinal phases give exact values. acc = 0 gives (0, 255), 2^22 gives (255, 0), 2^23 gives (0, -255) and 3*2^22 gives (-255, 0), each listed as (sin, cos).
- R11: The outputs are 9-bit two's complement and never take the code -256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Phase advance enable |
| freq_word | input | 24 | Phase increment per enabled clock |
| sin_out | output | 9 | Signed sine sample |
| cos_out | output | 9 | Signed cosine sample |

## Verification
The embedded assertions watch, on every cycle, the properties that hold for any tuning word. The phase register holds while advance is off, and each output's sign agrees with the octant sign control that produced it. No output takes the forbidden code. The pair stays near a circle of radius 255, and the outputs freeze once a held phase has passed through the pipeline. Only the bench scenarios can show the exact three-clock alignment with the phase register. They also show the accuracy against a double-precision sine and cosine across slow, near-Nyquist, wrapping and gated sweeps. Finally, the exact cardinal, mirrored, swapped and half-turn values are reached by loading chosen phases.

// File: rtl/qdds_pkg.sv
// Shared sizes, table entry type and the first-octant point table of the
// interpolating quadrature synthesizer.
// Assumes a 16-point table and a 9-bit signed output of amplitude 255.
package qdds_pkg;

    localparam int TBL_IDX_W = 4;   // table index bits (16 points)
    localparam int SAMP_W    = 8;   // stored sample magnitude bits
    localparam int STEP_W    = 4;   // stored slope magnitude bits

    typedef struct packed {
        logic [SAMP_W-1:0] sin_base;
        logic [STEP_W-1:0] sin_step;
        logic [SAMP_W-1:0] cos_base;
        logic [STEP_W-1:0] cos_step;
    } oct_entry_t;

    // Point k lies at angle k*pi/64; steps are the rise (sine) or fall
    // (cosine) to point k+1, so interval ends meet exactly.
    function automatic oct_entry_t oct_lookup(input logic [TBL_IDX_W-1:0] idx);
        oct_entry_t e;
        case (idx)
            4'd0:    e = '{8'd0,   4'd13, 8'd255, 4'd0};
            4'd1:    e = '{8'd13,  4'd12, 8'd255, 4'd1};
            4'd2:    e = '{8'd25,  4'd12, 8'd254, 4'd2};
            4'd3:    e = '{8'd37,  4'd13, 8'd252, 4'd2};
            4'd4:    e = '{8'd50,  4'd12, 8'd250, 4'd3};
            4'd5:    e = '{8'd62,  4'd12, 8'd247, 4'd3};
            4'd6:    e = '{8'd74,  4'd12, 8'd244, 4'd4};
            4'd7:    e = '{8'd86,  4'd12, 8'd240, 4'd4};
            4'd8:    e = '{8'd98,  4'd11, 8'd236, 4'd5};
            4'd9:    e = '{8'd109, 4'd11, 8'd231, 4'd6};
            4'd10:   e = '{8'd120, 4'd11, 8'd225, 4'd6};
            4'd11:   e = '{8'd131, 4'd11, 8'd219, 4'd7};
            4'd12:   e = '{8'd142, 4'd10, 8'd212, 4'd7};
            4'd13:   e = '{8'd152, 4'd10, 8'd205, 4'd8};
            4'd14:   e = '{8'd162, 4'd9,  8'd197, 4'd8};
            default: e = '{8'd171, 4'd9,  8'd189, 4'd9};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/qdds_phase_acc.sv
// Phase register and first pipeline stage.
// Adds the tuning word on every enabled clock (modulo 2^ACC_W) and registers
// the top PH_W bits as the working phase. Assumes PH_W <= ACC_W.
module qdds_phase_acc #(
    parameter int ACC_W = 24,
    parameter int PH_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [ACC_W-1:0] freq_word,
    output logic [PH_W-1:0]  phase_q
);

    logic [ACC_W-1:0] acc_q;

    // Advance the phase register when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (run_en) acc_q <= acc_q + freq_word;
    end

    // Capture the truncated working phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= acc_q[ACC_W-1 -: PH_W];
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_en)) |-> (acc_q == $past(acc_q)))
        else $error("phase register moved while disabled"); // R2

endmodule

// File: rtl/qdds_octant_fold.sv
// Second pipeline stage: octant folding, table lookup and lane routing.
// The third phase MSB mirrors the in-octant field. The XOR of the second and
// third MSBs swaps the sine/cosine lanes. The first MSB (and first XOR second
// for cosine) marks negation. Assumes M_W equals the package table index width.
module qdds_octant_fold #(
    parameter int M_W    = qdds_pkg::TBL_IDX_W,
    parameter int N_W    = 6,
    parameter int SAMP_W = qdds_pkg::SAMP_W,
    parameter int STEP_W = qdds_pkg::STEP_W,
    localparam int F_W   = M_W + N_W,
    localparam int PH_W  = F_W + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PH_W-1:0]        phase,
    output logic [1:0][SAMP_W-1:0] base_q,
    output logic [1:0][STEP_W:0]   slope_q,
    output logic [N_W-1:0]         off_q,
    output logic [1:0]             neg_q
);

    logic               half_b, quad_b, mirror_b, swap_b;
    logic [F_W-1:0]     folded;
    qdds_pkg::oct_entry_t ent;
    logic [SAMP_W-1:0]  st_base, ct_base;
    logic [STEP_W:0]    st_slope, ct_slope;

    // Decode octant controls and fold the field into the first octant.
    always_comb begin
        half_b   = phase[PH_W-1];
        quad_b   = phase[PH_W-2];
        mirror_b = phase[PH_W-3];
        swap_b   = quad_b ^ mirror_b;
        folded   = phase[F_W-1:0] ^ {F_W{mirror_b}};
    end

    // Look up the interval sample and slope for both angle lanes.
    always_comb begin
        ent      = qdds_pkg::oct_lookup(folded[F_W-1 -: M_W]);
        st_base  = ent.sin_base;
        st_slope = {1'b0, ent.sin_step};
        ct_base  = ent.cos_base;
        ct_slope = -{1'b0, ent.cos_step};
    end

    // Register the routed lanes, offset and sign marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            slope_q <= '0;
            off_q   <= '0;
            neg_q   <= '0;
        end else begin
            base_q[0]  <= swap_b ? ct_base  : st_base;
            slope_q[0] <= swap_b ? ct_slope : st_slope;
            base_q[1]  <= swap_b ? st_base  : ct_base;
            slope_q[1] <= swap_b ? st_slope : ct_slope;
            off_q      <= folded[N_W-1:0];
            neg_q[0]   <= half_b;
            neg_q[1]   <= half_b ^ quad_b;
        end
    end

endmodule

// File: rtl/qdds_interp_lane.sv
// Third pipeline stage for one output: sample plus rounded offset*slope/2^N_W,
// then optional negation. Assumes the interpolated magnitude fits OUT_W-1 bits.
module qdds_interp_lane #(
    parameter int N_W    = 6,
    parameter int SAMP_W = qdds_pkg::SAMP_W,
    parameter int STEP_W = qdds_pkg::STEP_W,
    parameter int OUT_W  = 9,
    localparam int W2    = OUT_W + 1 + N_W,
    localparam int RND   = 1 << (N_W - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SAMP_W-1:0]       base,
    input  logic signed [STEP_W:0]  slope,
    input  logic [N_W-1:0]          offset,
    input  logic                    neg,
    output logic signed [OUT_W-1:0] q
);

    logic signed [W2-1:0]    wide;
    logic signed [OUT_W-1:0] mag;

    // Scale the sample up, add offset*slope and the rounding half, scale back.
    always_comb begin
        wide = ($signed(W2'(base)) <<< N_W)
             + ($signed(W2'({1'b0, offset})) * W2'(slope))
             + W2'(RND);
        mag  = OUT_W'(wide >>> N_W);
    end

    // Register the signed result.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= neg ? -mag : mag;
    end

    AST_LANE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(neg) |-> (q <= 0))
        else $error("negated lane produced a positive value"); // R7
    AST_LANE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(neg) |-> (q >= 0))
        else $error("plain lane produced a negative value"); // R7

endmodule

// File: rtl/quad_interp_dds.sv
// Top of the interpolating quadrature synthesizer.
// Chain: phase register -> phase stage -> fold/lookup stage -> interpolation
// lanes (generated, sine then cosine). Outputs follow the phase register by
// three clocks. Assumes the default 16-point table and 9-bit output.
module quad_interp_dds #(
    parameter int ACC_W = 24,
    parameter int M_W   = qdds_pkg::TBL_IDX_W,
    parameter int N_W   = 6,
    parameter int OUT_W = 9,
    localparam int PH_W   = M_W + N_W + 3,
    localparam int SAMP_W = qdds_pkg::SAMP_W,
    localparam int STEP_W = qdds_pkg::STEP_W,
    localparam int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic [ACC_W-1:0]        freq_word,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);

    logic [PH_W-1:0]               phase_q;
    logic [LANES-1:0][SAMP_W-1:0]  base_q;
    logic [LANES-1:0][STEP_W:0]    slope_q;
    logic [N_W-1:0]                off_q;
    logic [LANES-1:0]              neg_q;
    logic signed [OUT_W-1:0]       lane_q [LANES];

    qdds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .freq_word(freq_word), .phase_q(phase_q)
    );

    qdds_octant_fold #(.M_W(M_W), .N_W(N_W), .SAMP_W(SAMP_W), .STEP_W(STEP_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .phase(phase_q),
        .base_q(base_q), .slope_q(slope_q), .off_q(off_q), .neg_q(neg_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qdds_interp_lane #(.N_W(N_W), .SAMP_W(SAMP_W), .STEP_W(STEP_W), .OUT_W(OUT_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .base(base_q[g]), .slope($signed(slope_q[g])),
            .offset(off_q), .neg(neg_q[g]), .q(lane_q[g])
        );
    end

    assign sin_out = lane_q[0];
    assign cos_out = lane_q[1];

    // ---- checks on the output pair ----
    localparam int AMP    = (1 << (OUT_W - 1)) - 1;
    localparam int RAD_W  = 2 * OUT_W + 2;
    localparam int RAD_LO = (AMP - 4) * (AMP - 4);
    localparam int RAD_HI = (AMP + 4) * (AMP + 4);

    logic [2:0]              since_rst;
    logic signed [RAD_W-1:0] s_ext, c_ext, rad_sq;

    // Count clocks since reset release (saturating) to arm the pair checks.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // Squared radius of the current output pair.
    always_comb begin
        s_ext  = RAD_W'(sin_out);
        c_ext  = RAD_W'(cos_out);
        rad_sq = s_ext * s_ext + c_ext * c_ext;
    end

    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_out != {1'b1, {(OUT_W-1){1'b0}}}) && (cos_out != {1'b1, {(OUT_W-1){1'b0}}}))
        else $error("output took the most negative code"); // R11
    AST_QUAD_RADIUS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3) |-> ((rad_sq >= RAD_W'(RAD_LO)) && (rad_sq <= RAD_W'(RAD_HI))))
        else $error("output pair left the unit circle band"); // R9
    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd6) && !$past(run_en, 4)) |->
        ((sin_out == $past(sin_out)) && (cos_out == $past(cos_out))))
        else $error("outputs moved after a held phase"); // R2

endmodule

// File: tb/quad_interp_dds_tb.sv
// Scoreboard bench: a driver task applies the tuning word and enable and
// queues the expected phase register value; a monitor task pops the entry
// three clocks later and compares both outputs with a double reference.
module quad_interp_dds_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 24;
    localparam int OUT_W = 9;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct {
        logic [ACC_W-1:0] acc;
        string            tag;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [ACC_W-1:0] freq_word = '0;
    logic signed [OUT_W-1:0] sin_out, cos_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [ACC_W-1:0] acc_model = '0;
    logic [15:0] lfsr = 16'hACE1;
    sb_item_t sb_q[$];

    quad_interp_dds u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .freq_word(freq_word), .sin_out(sin_out), .cos_out(cos_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic check_eq(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(string req, int act, real exp);
        real d;
        n_vec++;
        d = real'(act) - exp;
        if (d > 3.0 || d < -3.0) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0.2f", req, act, exp);
        end
    endtask

    // Monitor: compare outputs with the entry queued three clocks earlier.
    task automatic mon_step();
        sb_item_t e;
        real ang;
        if (sb_q.size() == 4) begin
            e   = sb_q.pop_front();
            ang = TWO_PI * real'(e.acc) / 16777216.0;
            check_near({e.tag, " R3 R9 sin"}, int'(sin_out), 255.0 * $sin(ang));
            check_near({e.tag, " R3 R9 cos"}, int'(cos_out), 255.0 * $cos(ang));
            check_eq("R11 no min code", int'(sin_out == -9'sd256 || cos_out == -9'sd256), 0);
        end
    endtask

    // Driver: apply inputs for the next edge and queue the resulting phase.
    task automatic drv_step(logic [ACC_W-1:0] fw, logic en, string tag);
        sb_item_t e;
        freq_word = fw;
        run_en    = en;
        if (en) acc_model = acc_model + fw;   // R1: wraps modulo 2^24
        e.acc = acc_model;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // en_mode: 0 off, 1 on, 2 pseudo-random gating.
    task automatic run_seg(logic [ACC_W-1:0] fw, int cycles, int en_mode, string tag);
        for (int i = 0; i < cycles; i++) begin
            logic en;
            mon_step();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en = (en_mode == 1) ? 1'b1 : (en_mode == 2) ? lfsr[0] : 1'b0;
            drv_step(fw, en, tag);
            @(negedge clk);
        end
    endtask

    // Load phase register value t through one enabled step after reset.
    task automatic exact_pt(logic [ACC_W-1:0] t, int es, int ec, string req);
        sb_q.delete();
        rst_n = 1'b0; run_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; freq_word = t; run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        repeat (5) @(negedge clk);
        check_eq({req, " sin"}, int'(sin_out), es);
        check_eq({req, " cos"}, int'(cos_out), ec);
    endtask

    initial begin
        int held_s, held_c;
        repeat (3) @(negedge clk);
        check_eq("R4 reset sin", int'(sin_out), 0);
        check_eq("R4 reset cos", int'(cos_out), 0);
        rst_n = 1'b1;
        acc_model = '0;
        run_seg(24'h001357, 600, 1, "R8 slow sweep");
        run_seg(24'h2AAAAB, 300, 1, "R1 wrap");
        run_seg(24'h7FF123, 300, 2, "R2 gated near-Nyquist");
        run_seg(24'hFFF000, 300, 1, "R5 reverse");
        run_seg(24'h0C0001, 400, 2, "R6 gated mid");
        // R2: hold the phase, then outputs must not move.
        run_seg(24'h123456, 5, 0, "R2 hold");
        held_s = int'(sin_out);
        held_c = int'(cos_out);
        repeat (3) @(negedge clk);
        check_eq("R2 held sin", int'(sin_out), held_s);
        check_eq("R2 held cos", int'(cos_out), held_c);
        // Exact phase points.
        exact_pt(24'd0,        0,    255, "R10 R4 zero");
        exact_pt(24'd4194304,  255,  0,   "R10 quarter");
        exact_pt(24'd8388608,  0,   -255, "R10 half");
        exact_pt(24'd12582912, -255, 0,   "R10 three-quarter");
        exact_pt(24'd2097152,  180,  180, "R5 mirrored octant end");
        exact_pt(24'd1048576,  98,   236, "R8 table point");
        exact_pt(24'd1114112,  104,  234, "R8 interpolated");
        exact_pt(24'd9502720,  -104, -234, "R7 half-turn negation");
        exact_pt(24'd5308416,  234,  -104, "R6 lane swap");
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule